// File: doc/BRIEF.md
# Phase-Clocked Bus Register Slave

This block places four byte-wide registers on a shared, phase-clocked processor bus. The bus master drives a phase clock `phi2`, a read/write line `rw` (1 means read), an address and a chip select. The block answers reads by driving `dout` with `oe` asserted, and it accepts writes on the falling edge of `phi2`. The address is never registered at the start of the bus phase. Select and read data follow the address for as long as `phi2` is high. Reads change nothing. Together these two properties let a second master own the bus while `phi2` is low.

Every bus input is sampled by a faster local clock `clk`. A qualified copy of `phi2` rises only after address, select and `rw` have held steady for `SETTLE` local cycles, and it falls as soon as `phi2` falls. The write strobe is select AND write AND this qualified phase. A write that is aborted or still unsettled when `phi2` falls therefore leaves no trace. An external event input sets an interrupt flag, and software clears the flag by writing a one to it. The active-low `irq_n` output follows the flag gated by an enable bit. The bus carries no back-pressure: a read is answered within the phase, and a write is always taken once it has qualified.

Top module: `pbus_reg_slave`

## Requirements
- R1: `oe` is 1 only while `phi2` is high, `cs` is 1 and `rw` is 1 (read). It is 0 whenever `phi2` is low, and it is 0 as soon as `rw` goes to 0, even in the middle of a phase.
- R2: `dout` always shows the register selected by the current `addr`. A change of address while `phi2` is high shows the new register's contents within the same local clock period, with no clock edge needed.
- R3: A read has no side effect. Reading the status register any number of times leaves the interrupt flag and `irq_n` unchanged.
- R4: A qualified write takes effect at the first `clk` edge after `phi2` falls. The value stored is `din` as sampled at the last `clk` edge while `phi2` was high.
- R5: A bus phase with `cs` low writes nothing.
- R6: A write occurs only when `phi2`, `cs`, `rw` = 0 and `addr` have all held steady for at least SETTLE+2 consecutive `clk` edges with `phi2` high. With SETTLE = 2 this means 4 edges; 3 edges write nothing. If `rw` returns to 1, or `addr` changes, before `phi2` falls, no write occurs.
- R7: The register map is as follows. Offset 0 is a data register and offset 3 is a scratch register, each 8 bits, fully readable and writable. Offset 1 is the control register, also fully writable, with the interrupt enable in bit 0. Offset 2 is the status register, which reads the interrupt flag in bit 7 and 0 in bits 6..0.
- R8: A 1 on `evt` at a `clk` edge sets the flag. A write to offset 2 with bit 7 = 1 clears it. A write with bit 7 = 0 leaves it as it was. When a set and a clear land on the same edge, the set wins.
- R9: `irq_n` is 0 exactly when the flag and control bit 0 are both 1.
- R10: After reset all registers and the flag read 0, `irq_n` is 1 and `oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, faster than `phi2` |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Bus phase clock; bus transfers happen while high |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W (2) | Register offset |
| din | input | DATA_W (8) | Write data from the bus |
| evt | input | 1 | Interrupt event, sets the flag |
| dout | output | DATA_W (8) | Read data, follows `addr` |
| oe | output | 1 | Data bus output enable |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
`oe` and `dout` have no register in their path, so the bench samples them one time unit after it changes `phi2`, `rw` or `addr`, inside the same `clk` period. A write needs SETTLE+2 stable high edges to arm, and it lands on the first edge after `phi2` falls. The bench therefore always lets one low edge pass before it reads a register back, and it places its arming-boundary cases at exactly 3 and 4 high edges. The flag is set one edge after `evt` is sampled high, and `irq_n` follows the registered flag and enable without a further delay. All inputs change on the falling edge of `clk`, and every result is read between edges.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int REG_DATA = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_STAT = 2;
  localparam int REG_SCR  = 3;
  localparam int IE_BIT   = 0;
  localparam int FLAG_BIT = 7;
endpackage

// File: rtl/pbus_qualify.sv
// Builds the qualified phase and write strobe from bus inputs sampled on clk.
// The qualified phase rises only after SETTLE stable cycles and drops at once.
module pbus_qualify #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cs,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int CNT_W = $clog2(SETTLE + 1) + 1;

  logic              phi2_d, cs_d, rw_d;
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt;
  logic              stable, phase_q, strobe, pend;

  // inputs unchanged since the previous edge, phase held high
  assign stable  = phi2 && phi2_d && (cs == cs_d) && (rw == rw_d) && (addr == addr_d);
  // qualified phase: late rise, immediate fall with phi2 or any disturbance
  assign phase_q = stable && (cnt >= CNT_W'(SETTLE));
  assign strobe  = phase_q && cs && !rw;
  assign commit  = !phi2 && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_d <= 1'b0;
      cs_d   <= 1'b0;
      rw_d   <= 1'b1;
      addr_d <= '0;
      cnt    <= '0;
    end else begin
      phi2_d <= phi2;
      cs_d   <= cs;
      rw_d   <= rw;
      addr_d <= addr;
      if (!stable)
        cnt <= '0;
      else if (cnt < CNT_W'(SETTLE))
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else if (phi2) begin
      if (strobe) begin
        pend        <= 1'b1;
        commit_addr <= addr;
        commit_data <= din;
      end else begin
        pend <= 1'b0;
      end
    end else begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pbus_regs.sv
// Register file: plain byte registers plus the status register with its flag.
module pbus_regs
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit,
  input  logic [ADDR_W-1:0]               commit_addr,
  input  logic [DATA_W-1:0]               commit_data,
  input  logic                            evt,
  output logic [(2**ADDR_W)-1:0][DATA_W-1:0] view,
  output logic                            irq_n
);
  localparam int NREG = 2 ** ADDR_W;

  logic flag;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == REG_STAT) begin : g_stat
      logic clr;
      assign clr = commit && (commit_addr == ADDR_W'(g)) && commit_data[FLAG_BIT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flag <= 1'b0;
        else if (evt)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
      end
      always_comb begin
        view[g]           = '0;
        view[g][FLAG_BIT] = flag;
      end
    end else begin : g_plain
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          r <= '0;
        else if (commit && (commit_addr == ADDR_W'(g)))
          r <= commit_data;
      end
      assign view[g] = r;
    end
  end

  assign irq_n = !(flag && view[REG_CTRL][IE_BIT]);
endmodule

// File: rtl/pbus_rdmux.sv
// Combinational read path: data follows the address, enable gated by phase.
module pbus_rdmux #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic [(2**ADDR_W)-1:0][DATA_W-1:0] view,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            phi2,
  input  logic                            cs,
  input  logic                            rw,
  output logic [DATA_W-1:0]               dout,
  output logic                            oe
);
  assign dout = view[addr];
  assign oe   = phi2 && cs && rw;
endmodule

// File: rtl/pbus_reg_slave.sv
module pbus_reg_slave
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cs,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              evt,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              irq_n
);
  localparam int NREG = 2 ** ADDR_W;

  logic                         wr_commit;
  logic [ADDR_W-1:0]            wr_addr;
  logic [DATA_W-1:0]            wr_data;
  logic [NREG-1:0][DATA_W-1:0]  reg_view;
  logic                         stat_flag;
  logic                         ctrl_ie;
  logic [DATA_W-1:0]            reg_data0;

  assign stat_flag = reg_view[REG_STAT][FLAG_BIT];
  assign ctrl_ie   = reg_view[REG_CTRL][IE_BIT];
  assign reg_data0 = reg_view[REG_DATA];

  pbus_qualify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_qual (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs(cs), .rw(rw), .addr(addr),
    .din(din), .commit(wr_commit), .commit_addr(wr_addr), .commit_data(wr_data)
  );

  pbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit), .commit_addr(wr_addr),
    .commit_data(wr_data), .evt(evt), .view(reg_view), .irq_n(irq_n)
  );

  pbus_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .view(reg_view), .addr(addr), .phi2(phi2), .cs(cs), .rw(rw),
    .dout(dout), .oe(oe)
  );
endmodule

// File: rtl/pbus_chk.sv
module pbus_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi2,
  input logic              cs,
  input logic              rw,
  input logic              oe,
  input logic              evt,
  input logic              commit,
  input logic              flag,
  input logic [DATA_W-1:0] reg0
);
  assert_oe_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> !oe);
  assert_oe_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> !oe);
  assert_read_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && rw && !evt) |=> $stable(flag));
  assert_commit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !phi2);
  assert_reg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(reg0));
  assert_commit_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(phi2 && cs && !rw));
  assert_evt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
endmodule

bind pbus_reg_slave pbus_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs(cs), .rw(rw), .oe(oe),
  .evt(evt), .commit(wr_commit), .flag(stat_flag), .reg0(reg_data0)
);

// File: tb/tb_pbus_reg_slave.sv
module tb_pbus_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phi2 = 1'b0, cs = 1'b0, rw = 1'b1, evt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          oe, irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] m [4];
  logic m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_reg_slave #(.ADDR_W(AW), .DATA_W(DW), .SETTLE(2)) dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs(cs), .rw(rw), .addr(addr),
    .din(din), .evt(evt), .dout(dout), .oe(oe), .irq_n(irq_n)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] stat_exp();
    return {m_flag, 7'b0};
  endfunction

  function automatic logic irq_exp();
    return !(m_flag && m[1][0]);
  endfunction

  // bus write: hi = clk edges with phi2 high; sel = chip select
  task automatic wr(input int a, input logic [DW-1:0] d, input int hi, input logic sel);
    @(negedge clk);
    phi2 = 1'b0; addr = AW'(a); rw = 1'b0; cs = sel; din = d;
    @(negedge clk);
    phi2 = 1'b1;
    #1 chk(oe, 1'b0, "R1 oe low during write");
    repeat (hi) @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    phi2 = 1'b0; addr = AW'(a); rw = 1'b1; cs = 1'b1;
    #1 chk(oe, 1'b0, "R1 oe low in phi2 low");
    @(negedge clk);
    phi2 = 1'b1;
    #1 chk(oe, 1'b1, "R1 oe high on read");
    chk(dout, e, tag);
    repeat (2) @(negedge clk);
    phi2 = 1'b0; cs = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    #1 chk(irq_n, 1'b1, "R10 irq_n in reset");
    chk(oe, 1'b0, "R10 oe in reset");
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(a, 8'h00, "R10 reset value");

    // sweep of writable registers with computed patterns (R7, R4)
    for (int k = 0; k < 10; k++) begin
      for (int a = 0; a < 4; a++) begin
        logic [DW-1:0] v;
        if (a == 2) continue;
        v = DW'((a * 37 + k * 53) ^ (k << 4));
        if (k == 8) v = 8'hFF;
        if (k == 9) v = 8'h00;
        wr(a, v, 6, 1'b1);
        m[a] = v;
      end
      for (int a = 0; a < 4; a++)
        rd(a, (a == 2) ? stat_exp() : m[a], "R7 sweep readback");
      #1 chk(irq_n, irq_exp(), "R9 irq with flag clear");
    end

    // status write with flag clear: reads zero in every bit (R7)
    wr(2, 8'hFF, 6, 1'b1);
    rd(2, 8'h00, "R7 status reads zero");

    // event sets flag (R8); reads leave it (R3)
    wr(1, 8'h00, 6, 1'b1); m[1] = 8'h00;
    @(negedge clk) evt = 1'b1;
    @(negedge clk) evt = 1'b0;
    m_flag = 1'b1;
    #1 chk(irq_n, 1'b1, "R9 flag set but enable off");
    rd(2, stat_exp(), "R8 event sets flag");
    rd(2, stat_exp(), "R3 second read keeps flag");
    rd(2, stat_exp(), "R3 third read keeps flag");
    wr(1, 8'h01, 6, 1'b1); m[1] = 8'h01;
    #1 chk(irq_n, 1'b0, "R9 irq asserted");
    rd(2, stat_exp(), "R3 read with irq active");
    #1 chk(irq_n, 1'b0, "R3 irq kept after read");
    wr(2, 8'h7F, 6, 1'b1);
    rd(2, 8'h80, "R8 write zero to bit7 keeps flag");
    // set and clear together: set wins
    evt = 1'b1;
    wr(2, 8'h80, 6, 1'b1);
    evt = 1'b0;
    rd(2, 8'h80, "R8 set beats clear");
    wr(2, 8'h80, 6, 1'b1); m_flag = 1'b0;
    rd(2, 8'h00, "R8 write one clears flag");
    #1 chk(irq_n, 1'b1, "R9 irq released");

    // unselected write (R5)
    wr(0, 8'h5A, 6, 1'b0);
    rd(0, m[0], "R5 unselected write ignored");

    // arming boundary (R6): 3 high edges no write, 4 high edges write
    wr(3, 8'hC3, 3, 1'b1);
    rd(3, m[3], "R6 3 edges no write");
    wr(3, 8'hC3, 4, 1'b1); m[3] = 8'hC3;
    rd(3, m[3], "R6 4 edges write");

    // write turned to read mid-phase (R6, R1, R2)
    @(negedge clk);
    addr = 2'd0; rw = 1'b0; cs = 1'b1; din = 8'h99;
    @(negedge clk) phi2 = 1'b1;
    repeat (6) @(negedge clk);
    rw = 1'b1;
    #1 chk(oe, 1'b1, "R1 oe on switch to read");
    chk(dout, m[0], "R2 data on switch to read");
    repeat (2) @(negedge clk);
    rw = 1'b0;
    #1 chk(oe, 1'b0, "R1 oe drops on write mid-phase");
    phi2 = 1'b0;
    @(negedge clk) cs = 1'b0; rw = 1'b1;
    rd(0, m[0], "R6 aborted write leaves register");

    // address wandering during the phase (R6)
    @(negedge clk);
    addr = 2'd0; rw = 1'b0; cs = 1'b1; din = 8'h11;
    @(negedge clk) phi2 = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) addr = (i % 2 == 0) ? 2'd3 : 2'd0;
    end
    @(negedge clk) phi2 = 1'b0;
    @(negedge clk) cs = 1'b0; rw = 1'b1;
    rd(0, m[0], "R6 unstable address data reg");
    rd(3, m[3], "R6 unstable address scratch reg");

    // data changes late in the phase: last sampled value stored (R4)
    @(negedge clk);
    addr = 2'd3; rw = 1'b0; cs = 1'b1; din = 8'h21;
    @(negedge clk) phi2 = 1'b1;
    repeat (5) @(negedge clk);
    din = 8'h6E;
    repeat (2) @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk) cs = 1'b0; rw = 1'b1; m[3] = 8'h6E;
    rd(3, m[3], "R4 last high-phase data stored");

    // address moves during a read phase (R2)
    @(negedge clk);
    addr = 2'd0; rw = 1'b1; cs = 1'b1;
    @(negedge clk) phi2 = 1'b1;
    for (int a = 0; a < 4; a++) begin
      addr = AW'(a);
      #1 chk(dout, (a == 2) ? stat_exp() : m[a], "R2 data follows address");
      @(negedge clk);
    end
    phi2 = 1'b0; cs = 1'b0;
    #1 chk(oe, 1'b0, "R1 oe off after phase");

    report();
  end
endmodule